// File: doc/BRIEF.md
# Opcode-Selected ALU with Comparison and Carry Flags

This block is a small arithmetic and logic unit. A 5-bit operation code selects one of the operations. Each one reads two WIDTH-bit operands, A and B, and produces a registered result that stands in for the new value of A. Next to the result it keeps a four-bit flag register. The flags hold a carry/borrow bit, a greater-than bit, an equal bit and a zero bit.

The result and flags change only on a clock edge where the valid strobe is high. Every binary operation also compares its two operands in the same cycle, using their values before the operation. The zero flag always follows the final result. Logic-type operations force the carry low. The shift and carry-chained codes consume the carry held from the previous operation. A 32-bit internal shift register supplies the pseudo-random operation.

Top module: `opcode_alu`

## Requirements
- R1: After reset the result is 0 and the flags are 4'b1000. Flag bit 0 is carry, bit 1 is A>B, bit 2 is A==B and bit 3 is zero.
- R2: When valid_i is low at a clock edge, result_o and flags_o keep their values.
- R3: Greater-than and equal are cleared by every operation. For every code except 0, 1, 4, 9, 13 and 16–20 they are then set from unsigned A>B and A==B on the operands as presented.
- R4: The zero flag is set exactly when the result after the operation equals 0.
- R5: Code 2 gives A+B, code 3 gives A+B+carry and code 4 gives A+1. In each case carry receives the carry-out of the WIDTH-bit sum.
- R6: Code 5 gives A−B and code 6 gives A−B−carry. Code 7 gives B−A and code 8 gives B−A−carry. Code 9 gives A−1. In each case carry receives the borrow, meaning the true difference was negative.
- R7: Code 10 gives the low WIDTH bits of the unsigned product A×B. Carry is set when any of the upper WIDTH bits of the product is set.
- R8: Code 0 gives 0, code 1 gives all ones and code 11 gives a pseudo-random word; all three clear carry. For code 11, a 32-bit state s, set to 1 at reset, is first advanced to (s>>1) ^ (s[0] ? 32'h80200003 : 0). Bit i of the result is then the XOR of all bits j of the new state with j mod WIDTH = i.
- R9: Code 16 shifts left with 0 in and code 18 shifts right with 0 in. Code 17 shifts left with the old carry in and code 19 shifts right with the old carry in. All four load carry with the bit shifted out.
- R10: Code 20 gives ~A and codes 21–26 give AND, NAND, OR, NOR, XOR and XNOR of A and B. Code 27 gives A & ~B. All of these clear carry.
- R11: Code 31 keeps the result and clears carry.
- R12: Codes 12–15 and 28–30 keep both the result and carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Execute the operation on this edge |
| op_i | input | 5 | Operation code |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| result_o | output | WIDTH | Registered result |
| flags_o | output | 4 | {zero, equal, greater, carry} |

## Verification
Two things can land in the same cycle: the comparison of the operands, and an arithmetic operation that both reads and rewrites carry. The bench provokes this with directed vectors that use equal or ordered operands on the carry-chained add, subtract and shift codes, with the carry already set by the previous operation. Long random runs then mix codes, operand values and valid gaps. A behavioural model predicts the flag word and the result on every clock, and the bench compares both whole.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int OP_W   = 5;
  localparam int FLAG_W = 4;
  localparam int FC     = 0;
  localparam int FGT    = 1;
  localparam int FEQ    = 2;
  localparam int FZ     = 3;
  localparam int RND_W  = 32;
  localparam logic [RND_W-1:0] RND_TAPS = 32'h80200003;
  localparam logic [RND_W-1:0] RND_SEED = 32'h00000001;

  typedef enum logic [OP_W-1:0] {
    OP_CLR  = 5'd0,  OP_SET  = 5'd1,  OP_ADD  = 5'd2,  OP_ADDC = 5'd3,
    OP_INC  = 5'd4,  OP_SUB  = 5'd5,  OP_SUBC = 5'd6,  OP_RSUB = 5'd7,
    OP_RSBC = 5'd8,  OP_DEC  = 5'd9,  OP_MUL  = 5'd10, OP_RND  = 5'd11,
    OP_SHL  = 5'd16, OP_SHLC = 5'd17, OP_SHR  = 5'd18, OP_SHRC = 5'd19,
    OP_NOT  = 5'd20, OP_AND  = 5'd21, OP_NAND = 5'd22, OP_OR   = 5'd23,
    OP_NOR  = 5'd24, OP_XOR  = 5'd25, OP_XNOR = 5'd26, OP_BCLR = 5'd27,
    OP_CCLR = 5'd31
  } alu_op_e;

  function automatic logic is_binary(input logic [OP_W-1:0] op);
    return !(op inside {5'd0, 5'd1, 5'd4, 5'd9, 5'd13, [5'd16:5'd20]});
  endfunction

  function automatic logic clears_carry(input logic [OP_W-1:0] op);
    return op inside {5'd0, 5'd1, 5'd11, [5'd20:5'd27], 5'd31};
  endfunction

  function automatic logic is_reserved(input logic [OP_W-1:0] op);
    return op inside {[5'd12:5'd15], [5'd28:5'd30]};
  endfunction
endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);
  localparam int PW = 2 * WIDTH;

  logic [WIDTH-1:0] x, y;
  logic [WIDTH:0]   cin_ext, sum;
  logic             do_sub;
  logic [PW-1:0]    prod;

  always_comb begin
    x       = a_i;
    y       = b_i;
    cin_ext = '0;
    do_sub  = 1'b0;
    case (op_i)
      OP_ADDC: cin_ext[0] = carry_i;
      OP_INC:  y = WIDTH'(1);
      OP_SUB:  do_sub = 1'b1;
      OP_SUBC: begin do_sub = 1'b1; cin_ext[0] = carry_i; end
      OP_RSUB: begin do_sub = 1'b1; x = b_i; y = a_i; end
      OP_RSBC: begin do_sub = 1'b1; x = b_i; y = a_i; cin_ext[0] = carry_i; end
      OP_DEC:  begin do_sub = 1'b1; y = WIDTH'(1); end
      default: ;
    endcase
  end

  // bit WIDTH is carry-out for add, sign (borrow) for subtract
  assign sum  = do_sub ? ({1'b0, x} - {1'b0, y} - cin_ext)
                       : ({1'b0, x} + {1'b0, y} + cin_ext);
  assign prod = PW'(a_i) * PW'(b_i);

  always_comb begin
    if (op_i == OP_MUL) begin
      res_o   = prod[WIDTH-1:0];
      carry_o = |prod[PW-1:WIDTH];
    end else begin
      res_o   = sum[WIDTH-1:0];
      carry_o = sum[WIDTH];
    end
  end
endmodule

// File: rtl/alu_shift_logic.sv
module alu_shift_logic
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OP_W-1:0]  op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] res_o,
  output logic             carry_o
);
  localparam int MSB = WIDTH - 1;

  always_comb begin
    res_o   = a_i;
    carry_o = 1'b0;
    case (op_i)
      OP_CLR:  res_o = '0;
      OP_SET:  res_o = '1;
      OP_SHL:  begin res_o = {a_i[MSB-1:0], 1'b0};    carry_o = a_i[MSB]; end
      OP_SHLC: begin res_o = {a_i[MSB-1:0], carry_i}; carry_o = a_i[MSB]; end
      OP_SHR:  begin res_o = {1'b0, a_i[MSB:1]};      carry_o = a_i[0];   end
      OP_SHRC: begin res_o = {carry_i, a_i[MSB:1]};   carry_o = a_i[0];   end
      OP_NOT:  res_o = ~a_i;
      OP_AND:  res_o = a_i & b_i;
      OP_NAND: res_o = ~(a_i & b_i);
      OP_OR:   res_o = a_i | b_i;
      OP_NOR:  res_o = ~(a_i | b_i);
      OP_XOR:  res_o = a_i ^ b_i;
      OP_XNOR: res_o = ~(a_i ^ b_i);
      OP_BCLR: res_o = a_i & ~b_i;
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_rand.sv
module alu_rand
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             advance_i,
  output logic [WIDTH-1:0] rnd_o
);
  logic [RND_W-1:0] state_q, state_n;

  assign state_n = (state_q >> 1) ^ (state_q[0] ? RND_TAPS : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        state_q <= RND_SEED;
    else if (advance_i) state_q <= state_n;
  end

  // fold the whole next state onto the result width
  always_comb begin
    rnd_o = '0;
    for (int j = 0; j < RND_W; j++) rnd_o[j % WIDTH] = rnd_o[j % WIDTH] ^ state_n[j];
  end
endmodule

// File: rtl/opcode_alu.sv
module opcode_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [WIDTH-1:0]  a_i,
  input  logic [WIDTH-1:0]  b_i,
  output logic [WIDTH-1:0]  result_o,
  output logic [FLAG_W-1:0] flags_o
);
  logic [WIDTH-1:0]  res_q, res_n, ar_res, sl_res, rnd_res;
  logic [FLAG_W-1:0] flg_q, flg_n;
  logic              ar_c, sl_c, c_n;

  alu_arith #(.WIDTH(WIDTH)) u_arith (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .carry_i(flg_q[FC]),
    .res_o(ar_res), .carry_o(ar_c)
  );

  alu_shift_logic #(.WIDTH(WIDTH)) u_sl (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .carry_i(flg_q[FC]),
    .res_o(sl_res), .carry_o(sl_c)
  );

  alu_rand #(.WIDTH(WIDTH)) u_rand (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .advance_i(valid_i && op_i == OP_RND),
    .rnd_o(rnd_res)
  );

  always_comb begin
    res_n = res_q;
    c_n   = flg_q[FC];
    case (op_i) inside
      [5'd2:5'd10]:               begin res_n = ar_res; c_n = ar_c; end
      5'd0, 5'd1, [5'd16:5'd27]:  begin res_n = sl_res; c_n = sl_c; end
      5'd11:                      begin res_n = rnd_res; c_n = 1'b0; end
      5'd31:                      c_n = 1'b0;
      default: ;
    endcase
    flg_n[FC]  = c_n;
    flg_n[FGT] = is_binary(op_i) && (a_i > b_i);
    flg_n[FEQ] = is_binary(op_i) && (a_i == b_i);
    flg_n[FZ]  = (res_n == '0);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      flg_q <= 4'b1000;
    end else if (valid_i) begin
      res_q <= res_n;
      flg_q <= flg_n;
    end
  end

  assign result_o = res_q;
  assign flags_o  = flg_q;
endmodule

// File: rtl/opcode_alu_checker.sv
module opcode_alu_checker
  import alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [OP_W-1:0]   op_i,
  input logic [WIDTH-1:0]  a_i,
  input logic [WIDTH-1:0]  b_i,
  input logic [WIDTH-1:0]  result_o,
  input logic [FLAG_W-1:0] flags_o
);
  assert_idle_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(result_o) && $stable(flags_o));

  assert_cmp_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flags_o[FEQ:FGT]));

  assert_unary_nocmp_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !is_binary(op_i) |=> flags_o[FEQ:FGT] == 2'b00);

  assert_eq_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_binary(op_i) && a_i == b_i |=> flags_o[FEQ]);

  assert_gt_set_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_binary(op_i) && a_i > b_i |=> flags_o[FGT]);

  assert_zero_track_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flags_o[FZ] == (result_o == '0));

  assert_carry_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && clears_carry(op_i) |=> !flags_o[FC]);

  assert_cclr_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && op_i == OP_CCLR |=> $stable(result_o));

  assert_reserved_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && is_reserved(op_i) |=> $stable(result_o) && $stable(flags_o[FC]));
endmodule

bind opcode_alu opcode_alu_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
  .a_i(a_i), .b_i(b_i), .result_o(result_o), .flags_o(flags_o)
);

// File: tb/opcode_alu_tb_top.sv
module opcode_alu_tb_top;
  localparam int W = 8;
  localparam longint unsigned M = (64'd1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         valid = 1'b0;
  logic [4:0]   op = '0;
  logic [W-1:0] a = '0, b = '0;
  logic [W-1:0] res;
  logic [3:0]   flg;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  longint unsigned m_res = 0;
  bit [3:0]        m_flg = 4'b1000;
  bit [31:0]       m_lfsr = 32'h1;

  always #10 clk = ~clk;

  opcode_alu #(.WIDTH(W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .op_i(op),
    .a_i(a), .b_i(b), .result_o(res), .flags_o(flg)
  );

  function automatic string tag_of(bit v, int o);
    if (!v) return "R2";
    case (o)
      2, 3, 4:           return "R5";
      5, 6, 7, 8, 9:     return "R6";
      10:                return "R7";
      0, 1, 11:          return "R8";
      16, 17, 18, 19:    return "R9";
      20, 21, 22, 23, 24, 25, 26, 27: return "R10";
      31:                return "R11";
      default:           return "R12";
    endcase
  endfunction

  task automatic model(bit v, int o, longint unsigned x, longint unsigned y);
    longint unsigned r, s;
    bit c, ci;
    if (!v) return;
    ci = m_flg[0];
    r  = m_res;
    c  = ci;
    case (o)
      0:  begin r = 0; c = 0; end
      1:  begin r = M; c = 0; end
      2:  begin s = x + y;      r = s & M; c = s[W]; end
      3:  begin s = x + y + ci; r = s & M; c = s[W]; end
      4:  begin s = x + 1;      r = s & M; c = s[W]; end
      5:  begin r = (x - y) & M;      c = x < y; end
      6:  begin r = (x - y - ci) & M; c = x < y + ci; end
      7:  begin r = (y - x) & M;      c = y < x; end
      8:  begin r = (y - x - ci) & M; c = y < x + ci; end
      9:  begin r = (x - 1) & M;      c = (x == 0); end
      10: begin s = x * y; r = s & M; c = (s >> W) != 0; end
      11: begin
        m_lfsr = (m_lfsr >> 1) ^ (m_lfsr[0] ? 32'h80200003 : 32'h0);
        r = 0;
        for (int j = 0; j < 32; j++) if (m_lfsr[j]) r = r ^ (64'd1 << (j % W));
        c = 0;
      end
      16: begin c = x[W-1]; r = (x << 1) & M; end
      17: begin c = x[W-1]; r = ((x << 1) | ci) & M; end
      18: begin c = x[0];   r = x >> 1; end
      19: begin c = x[0];   r = (x >> 1) | (longint'(ci) << (W-1)); end
      20: begin r = ~x & M;       c = 0; end
      21: begin r = x & y;        c = 0; end
      22: begin r = ~(x & y) & M; c = 0; end
      23: begin r = x | y;        c = 0; end
      24: begin r = ~(x | y) & M; c = 0; end
      25: begin r = x ^ y;        c = 0; end
      26: begin r = ~(x ^ y) & M; c = 0; end
      27: begin r = x & ~y & M;   c = 0; end
      31: c = 0;
      default: ;
    endcase
    m_res = r;
    m_flg[0] = c;
    if (o inside {0, 1, 4, 9, 13, [16:20]}) m_flg[2:1] = 2'b00;
    else m_flg[2:1] = {x == y, x > y};
    m_flg[3] = (r == 0);
  endtask

  task automatic compare(string tag);
    n_vec++;
    if (res !== W'(m_res) || flg !== m_flg) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h: result %h flags %b, expected %h flags %b",
               tag, op, a, b, res, flg, W'(m_res), m_flg);
    end
  endtask

  task automatic apply(bit v, int o, int x, int y);
    @(negedge clk);
    valid = v; op = 5'(o); a = W'(x); b = W'(y);
    @(posedge clk);
    model(v, o, longint'(a), longint'(b));
    #2;
    compare(tag_of(v, o));
  endtask

  initial begin
    #(20 * 200000);
    n_bad++;
    $display("FAIL watchdog: run did not complete, expected completion");
    if (!done) begin
      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    end
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    // R5: carry-out then carried add with equal operands (compare and carry same cycle)
    apply(1, 2, 8'hF0, 8'h20);
    apply(1, 3, 8'h10, 8'h10);
    apply(1, 4, 8'hFF, 0);
    // R6: borrows, borrow consumed while operands compare greater
    apply(1, 5, 8'h03, 8'h05);
    apply(1, 6, 8'h05, 8'h04);
    apply(1, 7, 8'h05, 8'h03);
    apply(1, 8, 8'h07, 8'h07);
    apply(1, 9, 0, 0);
    // R7
    apply(1, 10, 8'h10, 8'h10);
    apply(1, 10, 8'h0F, 8'h11);
    // R8
    apply(1, 1, 0, 0);
    apply(1, 0, 8'h33, 8'h33);
    apply(1, 11, 1, 2);
    apply(1, 11, 3, 3);
    // R9: carry threaded through shifts
    apply(1, 16, 8'h81, 0);
    apply(1, 17, 8'h40, 0);
    apply(1, 18, 8'h01, 0);
    apply(1, 19, 8'h02, 0);
    apply(1, 19, 8'h80, 0);
    // R10
    apply(1, 2, 8'hFF, 8'h01);
    apply(1, 27, 8'hF0, 8'h30);
    apply(1, 26, 8'h5A, 8'h5A);
    // R12 then R11 with carry set
    apply(1, 2, 8'hFF, 8'h02);
    apply(1, 13, 8'h00, 8'h01);
    apply(1, 28, 8'h09, 8'h01);
    apply(1, 31, 8'h04, 8'h04);
    // R2: idle edges keep state
    apply(0, 0, 8'h12, 8'h34);
    apply(0, 2, 8'hFF, 8'hFF);
    // random mix, including compare-while-carry cases
    for (int i = 0; i < 4000; i++) begin
      int o, x, y;
      o = $urandom_range(0, 31);
      x = $urandom_range(0, 255);
      y = ($urandom_range(0, 3) == 0) ? x : $urandom_range(0, 255);
      apply($urandom_range(0, 7) != 0, o, x, y);
    end
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule